// File: doc/BRIEF.md
# Cascadable Interrupt Priority Chain

This block arbitrates interrupts among the sources on one peripheral card. The sources sit in a fixed order. A counter/timer source is first. Three parallel-port sources follow it. Priority does not come from a central encoder. It passes through a chain of stages, and each stage has an enable input and an enable output. A stage closes its enable output while it has a pending request or an interrupt under service. Every stage below it is then locked out. The card's own enable output drives the enable input of the next card on the bus, so several cards form one long priority chain. The card at the top of the chain has its enable input tied high.

When the processor acknowledges an interrupt, the single stage that sees an open enable input and holds a pending request is granted. The block presents that stage on a one-hot grant vector and as a vector identifier, and the stage latches an under-service flag. A return-from-service strobe clears the flag of the one stage whose enable input is open. That stage is the highest one still under service, so nested interrupts unwind in order. A source position can be marked as not fitted. Its stage then passes enable straight through and can never be granted. A serial port or any other source outside the chain is not handled here.

Top module: `irq_prio_chain`

## Requirements
- R1: After reset no source is under service, `grant_o` and `vec_o` are zero, and `ieo_o` equals `ien_i` while no request is present.
- R2: Priority is fixed by index. Source 0 (counter/timer) is highest, then sources 1, 2 and 3. On acknowledge, the lowest-indexed fitted source with a pending request is the one granted.
- R3: `ieo_o` is low whenever `ien_i` is low, or any fitted source has a pending request (`req_i` high and not under service), or any fitted source is under service. Otherwise it is high.
- R4: `grant_o` is nonzero only while `ack_i` is high. It has at most one bit set, and only for a stage whose enable input is open and whose request is pending. That stage becomes under service at the clock edge that ends the acknowledge, and while under service its request is not granted again.
- R5: While a grant is shown, `vec_o` equals `VEC_BASE + 2*k`, where k is the granted index. Otherwise `vec_o` is zero.
- R6: A cycle with `reti_i` high clears the under-service flag of only the stage whose enable input is open. With nested services, each strobe releases the highest one still active.
- R7: A source whose bit in `FITTED` is zero never appears in `grant_o`, and it passes enable from above to below unchanged, whatever its request input does.
- R8: With `ien_i` low the card grants nothing and holds `ieo_o` low. A lower card fed from `ieo_o` is blocked in the same way.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ien_i | input | 1 | Chain enable from the next higher-priority card (tie high at the top) |
| req_i | input | NUM_SRC | Interrupt request level per source, index 0 highest |
| ack_i | input | 1 | Interrupt acknowledge strobe |
| reti_i | input | 1 | Return-from-service strobe |
| ieo_o | output | 1 | Chain enable to the next lower-priority card |
| grant_o | output | NUM_SRC | One-hot grant during acknowledge |
| vec_o | output | VEC_W | Vector identifier of the granted source |

## Verification
The bench builds two cards in cascade. The upper card has all four sources fitted and a vector base of 0x40. Its enable output feeds a lower card that has source 1 unfitted (FITTED = 4'b1101) and a vector base of 0x80. With this pairing the bench can exercise pass-through across a missing stage, blocking across the card boundary, and two distinct vector ranges. A single-card build cannot show any of these.

// File: rtl/irq_chain_pkg.sv
package irq_chain_pkg;
  // default number of sources on one card
  localparam int unsigned SRC_COUNT_DFLT = 4;
  // spacing of vector identifiers between adjacent sources
  localparam int unsigned VEC_STEP = 2;
  // reset synchroniser depth
  localparam int unsigned RST_SYNC_DEPTH = 2;
endpackage

// File: rtl/irq_rst_sync.sv
module irq_rst_sync #(
  parameter int unsigned DEPTH = irq_chain_pkg::RST_SYNC_DEPTH
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [DEPTH-1:0] sync_q;
  logic [DEPTH-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[DEPTH-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign srst_n = sync_q[DEPTH-1];
endmodule

// File: rtl/irq_chain_stage.sv
module irq_chain_stage (
  input  logic clk,
  input  logic rst_n,
  input  logic ien_i,
  input  logic req_i,
  input  logic ack_i,
  input  logic reti_i,
  output logic ieo_o,
  output logic gnt_o
);
  logic srv_q;
  logic srv_d;
  logic srv_en;
  logic pend;

  always_comb begin
    pend   = req_i & ~srv_q;
    gnt_o  = ien_i & pend & ack_i;
    ieo_o  = ien_i & ~pend & ~srv_q;
    srv_en = gnt_o | (reti_i & ien_i & srv_q);
    srv_d  = srv_q;
    if (srv_en) srv_d = gnt_o;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) srv_q <= 1'b0;
    else        srv_q <= srv_d;
  end

  // R4
  srv_set_on_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(srv_q) |-> $past(ack_i && ien_i && req_i));
  // R6
  srv_clr_on_reti_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(srv_q) |-> $past(reti_i && ien_i));
  // R3
  srv_blocks_chain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    srv_q |-> !ieo_o);
endmodule

// File: rtl/irq_vec_encode.sv
module irq_vec_encode #(
  parameter int unsigned NUM_SRC  = irq_chain_pkg::SRC_COUNT_DFLT,
  parameter int unsigned VEC_W    = 8,
  parameter logic [VEC_W-1:0] VEC_BASE = '0
) (
  input  logic [NUM_SRC-1:0] grant_i,
  output logic [VEC_W-1:0]   vec_o
);
  localparam logic [VEC_W-1:0] STEP = VEC_W'(irq_chain_pkg::VEC_STEP);

  always_comb begin
    vec_o = '0;
    for (int k = 0; k < NUM_SRC; k++) begin
      if (grant_i[k]) vec_o = VEC_BASE + VEC_W'(k) * STEP;
    end
  end
endmodule

// File: rtl/irq_prio_chain.sv
module irq_prio_chain #(
  parameter int unsigned NUM_SRC = irq_chain_pkg::SRC_COUNT_DFLT,
  parameter logic [NUM_SRC-1:0] FITTED = '1,
  parameter int unsigned VEC_W = 8,
  parameter logic [VEC_W-1:0] VEC_BASE = 8'h40
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ien_i,
  input  logic [NUM_SRC-1:0] req_i,
  input  logic               ack_i,
  input  logic               reti_i,
  output logic               ieo_o,
  output logic [NUM_SRC-1:0] grant_o,
  output logic [VEC_W-1:0]   vec_o
);
  logic               srst_n;
  logic [NUM_SRC:0]   chain;

  irq_rst_sync u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  assign chain[0] = ien_i;

  for (genvar k = 0; k < NUM_SRC; k++) begin : g_stage
    if (FITTED[k]) begin : g_fit
      irq_chain_stage u_stage (
        .clk    (clk),
        .rst_n  (srst_n),
        .ien_i  (chain[k]),
        .req_i  (req_i[k]),
        .ack_i  (ack_i),
        .reti_i (reti_i),
        .ieo_o  (chain[k+1]),
        .gnt_o  (grant_o[k])
      );
    end else begin : g_gap
      assign chain[k+1]  = chain[k];
      assign grant_o[k]  = 1'b0;
    end
  end

  assign ieo_o = chain[NUM_SRC];

  irq_vec_encode #(
    .NUM_SRC  (NUM_SRC),
    .VEC_W    (VEC_W),
    .VEC_BASE (VEC_BASE)
  ) u_vec (
    .grant_i (grant_o),
    .vec_o   (vec_o)
  );

  // R4
  grant_onehot_chk: assert property (@(posedge clk) disable iff (!srst_n)
    $onehot0(grant_o));
  // R4
  grant_needs_ack_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (grant_o != '0) |-> ack_i);
  // R8
  chain_break_chk: assert property (@(posedge clk) disable iff (!srst_n)
    !ien_i |-> (grant_o == '0 && !ieo_o));
  // R5
  vec_idle_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (grant_o == '0) |-> (vec_o == '0));
  // R7
  unfitted_silent_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (grant_o & ~FITTED) == '0);
endmodule

// File: tb/tb_irq_prio_chain.sv
module tb_irq_prio_chain;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       ien_top;
  logic [3:0] reqa, reqb;
  logic       ack, reti;
  logic       ieo_a, ieo_b;
  logic [3:0] gnt_a, gnt_b;
  logic [7:0] vec_a, vec_b;
  int         n_chk = 0;
  int         n_fail = 0;
  bit         done = 0;

  always #2.5 clk = ~clk;

  irq_prio_chain #(.FITTED(4'b1111), .VEC_BASE(8'h40)) dut (
    .clk(clk), .rst_n(rst_n), .ien_i(ien_top), .req_i(reqa), .ack_i(ack),
    .reti_i(reti), .ieo_o(ieo_a), .grant_o(gnt_a), .vec_o(vec_a));

  irq_prio_chain #(.FITTED(4'b1101), .VEC_BASE(8'h80)) dut_lo (
    .clk(clk), .rst_n(rst_n), .ien_i(ieo_a), .req_i(reqb), .ack_i(ack),
    .reti_i(reti), .ieo_o(ieo_b), .grant_o(gnt_b), .vec_o(vec_b));

  task automatic chk(input string rq, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  // drive at falling edge, settle
  task automatic nxt();
    @(negedge clk);
  endtask

  // one full clocked cycle with a strobe
  task automatic pulse_reti();
    nxt(); reti = 1'b1;
    nxt(); reti = 1'b0;
  endtask

  // show an acknowledge without letting it reach a clock edge
  task automatic peek_ack(input logic [3:0] r, input logic [3:0] eg, input logic [7:0] ev);
    nxt(); reqa = r; ack = 1'b1; #1;
    chk("R2 grant", {4'h0, gnt_a}, {4'h0, eg});
    chk("R5 vector", vec_a, ev);
    ack = 1'b0; #1;
    chk("R4 no grant w/o ack", {4'h0, gnt_a}, 8'h00);
    reqa = 4'h0;
  endtask

  task automatic t_reset();
    #1;
    chk("R1 ieo top", {7'h0, ieo_a}, 8'h01);
    chk("R1 ieo low card", {7'h0, ieo_b}, 8'h01);
    chk("R1 grant", {gnt_b, gnt_a}, 8'h00);
    chk("R1 vec", vec_a | vec_b, 8'h00);
  endtask

  task automatic t_priority();
    peek_ack(4'b1111, 4'b0001, 8'h40);
    peek_ack(4'b1110, 4'b0010, 8'h42);
    peek_ack(4'b1100, 4'b0100, 8'h44);
    peek_ack(4'b1000, 4'b1000, 8'h46);
    nxt(); #1;
    chk("R3 idle ieo", {7'h0, ieo_a}, 8'h01);
  endtask

  task automatic t_nesting();
    nxt(); reqa = 4'b1000; #1;
    chk("R3 pending blocks", {7'h0, ieo_a}, 8'h00);
    ack = 1'b1; #1;
    chk("R5 src3 vec", vec_a, 8'h46);
    nxt(); ack = 1'b0; reqa = 4'b0000; #1;
    chk("R3 under service blocks", {7'h0, ieo_a}, 8'h00);
    reqa = 4'b0001; ack = 1'b1; #1;
    chk("R4 nested grant", {4'h0, gnt_a}, 8'h01);
    nxt(); ack = 1'b0; reqa = 4'b0010; reti = 1'b1;
    nxt(); reti = 1'b0; ack = 1'b1; #1;
    chk("R6 src0 released first", {4'h0, gnt_a}, 8'h02);
    nxt(); ack = 1'b0; reqa = 4'b0000;
    pulse_reti(); #1;
    chk("R6 src3 still held", {7'h0, ieo_a}, 8'h00);
    pulse_reti(); #1;
    chk("R6 all released", {7'h0, ieo_a}, 8'h01);
    // request held across service is not granted again until released
    nxt(); reqa = 4'b0100; ack = 1'b1;
    nxt(); #1;
    chk("R4 no regrant under service", {4'h0, gnt_a}, 8'h00);
    ack = 1'b0; reqa = 4'b0000;
    pulse_reti(); #1;
    chk("R6 released", {7'h0, ieo_a}, 8'h01);
  endtask

  task automatic t_cascade();
    nxt(); reqb = 4'b0010; ack = 1'b1; #1;
    chk("R7 unfitted no grant", {4'h0, gnt_b}, 8'h00);
    chk("R7 pass-through", {7'h0, ieo_b}, 8'h01);
    ack = 1'b0;
    nxt(); reqb = 4'b0100; #1;
    chk("R3 low card pending", {7'h0, ieo_b}, 8'h00);
    ack = 1'b1; #1;
    chk("R7 grant past gap", {4'h0, gnt_b}, 8'h04);
    chk("R5 low card vec", vec_b, 8'h84);
    nxt(); ack = 1'b0; reqb = 4'b0000;
    pulse_reti(); #1;
    chk("R6 low card released", {7'h0, ieo_b}, 8'h01);
  endtask

  task automatic t_break();
    nxt(); reqa = 4'b0100; reqb = 4'b0001; ack = 1'b1; #1;
    chk("R8 upper wins", {4'h0, gnt_a}, 8'h04);
    chk("R8 lower card blocked", {4'h0, gnt_b}, 8'h00);
    nxt(); ack = 1'b0; reqa = 4'b0000; reqb = 4'b0000;
    pulse_reti(); #1;
    chk("R6 upper released", {7'h0, ieo_a}, 8'h01);
    nxt(); ien_top = 1'b0; reqa = 4'b0001; reqb = 4'b0001; ack = 1'b1; #1;
    chk("R8 no grant top", {4'h0, gnt_a}, 8'h00);
    chk("R8 no grant low", {4'h0, gnt_b}, 8'h00);
    chk("R8 ieo low", {7'h0, ieo_a}, 8'h00);
    ack = 1'b0; reqa = 4'b0000; reqb = 4'b0000;
    nxt(); #1;
    chk("R8 ieo low idle", {7'h0, ieo_a}, 8'h00);
    ien_top = 1'b1;
  endtask

  initial begin
    rst_n = 1'b0; ien_top = 1'b1; reqa = '0; reqb = '0; ack = 1'b0; reti = 1'b0;
    repeat (3) nxt();
    rst_n = 1'b1;
    repeat (4) nxt();
    t_reset();
    t_priority();
    t_nesting();
    t_cascade();
    t_break();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule